// File: doc/BRIEF.md
# SDRAM Command Decoder and Protocol Checker

This block is a passive observer placed beside the control pins of a synchronous DRAM. On every rising clock it samples chip select, the three strobe lines (RAS, CAS, WE), clock enable, the bank bits, the address bus and the byte masks. It reduces each sample to one command and reports that command, the bank, the address field that matters for that command, and the auto-precharge or precharge-all choice. It never drives the memory bus.

Beside the decoding, it keeps a model of each bank: whether a row is open, and which row. It uses that model and a mode-register settle counter to catch protocol misuse. Examples are opening a row in a bank that is already open, accessing a closed bank, refreshing or loading the mode register while a bank is open, and issuing a command too soon after a mode-register load. Each kind of misuse sets its own flag. The flags stay set until software-independent logic pulses a synchronous clear.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With chip select low, the strobes {RAS,CAS,WE} decode as 111 NOP, 011 ACTIVE, 101 READ, 100 WRITE, 110 BURST TERMINATE, 010 PRECHARGE, 001 REFRESH and 000 MODE LOAD. `cmd_o` uses the codes INHIBIT=0, NOP=1, ACTIVE=2, READ=3, WRITE=4, BURST TERMINATE=5, PRECHARGE=6, AUTO REFRESH=7, SELF REFRESH=8 and MODE LOAD=9.
- R2: Chip select high gives INHIBIT whatever the other pins are. An INHIBIT changes no bank state and no flag, and it is not a command for the mode-load settle window.
- R3: Every output shows the sample from the latest rising edge. `addr_o` carries the full address for ACTIVE and MODE LOAD, and the column (address bits 8..0, zero-extended) for READ and WRITE. For every other command it is 0. After reset, `cmd_o` is INHIBIT and all banks, flags and masks are 0.
- R4: For READ and WRITE, `ap_o` equals address bit 10. It is 0 for every other command, so the request does not persist.
- R5: ACTIVE marks bank `ba` open in `open_o` (bit n is bank n) and stores the address as that bank's row. Bank n's row sits in `open_rows_o` bits [12n+11:12n].
- R6: PRECHARGE with address bit 10 low closes only bank `ba`. With bit 10 high it closes every bank, whatever `ba` is, and `pre_all_o` is 1.
- R7: A READ or WRITE with address bit 10 high closes its bank at the edge that registers it.
- R8: ACTIVE to a bank that is already open sets `viol_o` bit 0.
- R9: READ or WRITE to a closed bank sets `viol_o` bit 1.
- R10: The refresh encoding is AUTO REFRESH when clock enable is high and SELF REFRESH when it is low. Either one while any bank is open sets `viol_o` bit 2.
- R11: MODE LOAD while any bank is open sets `viol_o` bit 3.
- R12: After a MODE LOAD, any command other than NOP or INHIBIT sampled fewer than TMRD edges later sets `viol_o` bit 4.
- R13: Flags are sticky. A sample with `clr_viol` high clears every flag, except a flag that the same sample raises.
- R14: `wr_mask_o` takes `dqm` on each WRITE and holds its value through every other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_viol | input | 1 | Synchronous clear of the violation flags |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Address bus |
| dqm | input | NBYTE | Byte masks |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W | Sampled bank |
| addr_o | output | ADDR_W | Row, column or op-code field |
| ap_o | output | 1 | Auto-precharge request of a READ or WRITE |
| pre_all_o | output | 1 | Precharge targets all banks |
| wr_mask_o | output | NBYTE | Byte masks of the latest WRITE |
| open_o | output | 2**BA_W | Per-bank open flags |
| open_rows_o | output | 2**BA_W*ADDR_W | Per-bank open row addresses |
| viol_o | output | 5 | Sticky violation flags |

## Verification
The bench builds the block with TMRD set to 3 rather than the default 2. This leaves two quiet cycles after a mode load, so one test can place a command inside the settle window and another can place one exactly on its edge. The other parameters keep their defaults: four banks, a 12-bit address and nine byte masks. With four banks, a precharge-all can close several open banks at once, including a bank whose select differs from the `ba` value on the precharge.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

    typedef enum logic [3:0] {
        CMD_INH  = 4'd0,
        CMD_NOP  = 4'd1,
        CMD_ACT  = 4'd2,
        CMD_RD   = 4'd3,
        CMD_WR   = 4'd4,
        CMD_BST  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_REF  = 4'd7,
        CMD_SREF = 4'd8,
        CMD_LMR  = 4'd9
    } sd_cmd_e;

    localparam int VIOL_W      = 5;
    localparam int V_ACT_OPEN  = 0;
    localparam int V_RW_CLOSED = 1;
    localparam int V_REF_OPEN  = 2;
    localparam int V_LMR_OPEN  = 3;
    localparam int V_MRD       = 4;

    typedef struct packed {
        sd_cmd_e cmd;
        logic    ap;
        logic    pre_all;
    } sd_dec_t;

    function automatic sd_cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                           input logic cas_n, input logic we_n,
                                           input logic cke);
        sd_cmd_e c;
        if (cs_n) begin
            c = CMD_INH;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b110:  c = CMD_BST;
                3'b010:  c = CMD_PRE;
                3'b001:  c = cke ? CMD_REF : CMD_SREF;
                default: c = CMD_LMR;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_exec(input sd_cmd_e c);
        return !(c == CMD_INH || c == CMD_NOP);
    endfunction

endpackage

// File: rtl/sdcm_decoder.sv
module sdcm_decoder
    import sdcm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 10
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [ADDR_W-1:0] addr,
    output sd_dec_t           dec_o,
    output logic [ADDR_W-1:0] field_o
);

    sd_cmd_e cmd;

    always_comb begin
        cmd           = decode_cmd(cs_n, ras_n, cas_n, we_n, cke);
        dec_o.cmd     = cmd;
        dec_o.ap      = 1'b0;
        dec_o.pre_all = 1'b0;
        field_o       = '0;
        case (cmd)
            CMD_ACT, CMD_LMR: field_o = addr;
            CMD_RD, CMD_WR: begin
                field_o[COL_W-1:0] = addr[COL_W-1:0];
                dec_o.ap           = addr[AP_BIT];
            end
            CMD_PRE: dec_o.pre_all = addr[AP_BIT];
            default: ;
        endcase
    end

endmodule

// File: rtl/sdcm_bank_tracker.sv
module sdcm_bank_tracker
    import sdcm_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 12,
    localparam int NBANK = 1 << BA_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  sd_dec_t                 dec,
    input  logic [BA_W-1:0]         ba,
    input  logic [ADDR_W-1:0]       addr,
    output logic [NBANK-1:0]        open_o,
    output logic [NBANK*ADDR_W-1:0] rows_o
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic              hit;
        logic [ADDR_W-1:0] row_q;

        assign hit = (ba == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_o[b] <= 1'b0;
                row_q     <= '0;
            end else if (dec.cmd == CMD_ACT && hit) begin
                open_o[b] <= 1'b1;
                row_q     <= addr;
            end else if (dec.cmd == CMD_PRE && (dec.pre_all || hit)) begin
                open_o[b] <= 1'b0;
            end else if ((dec.cmd == CMD_RD || dec.cmd == CMD_WR) && dec.ap && hit) begin
                open_o[b] <= 1'b0;
            end
        end

        assign rows_o[b*ADDR_W +: ADDR_W] = row_q;
    end

endmodule

// File: rtl/sdcm_rule_checker.sv
module sdcm_rule_checker
    import sdcm_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int TMRD   = 2,
    localparam int NBANK = 1 << BA_W,
    localparam int CNT_W = $clog2(TMRD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  sd_cmd_e           cmd,
    input  logic [BA_W-1:0]   ba,
    input  logic [NBANK-1:0]  open_i,
    output logic [VIOL_W-1:0] viol_o
);

    logic [CNT_W-1:0]  mrd_cnt;
    logic [VIOL_W-1:0] hit;
    logic              any_open;
    logic              bank_open;

    assign any_open  = |open_i;
    assign bank_open = open_i[ba];

    always_comb begin
        hit              = '0;
        hit[V_ACT_OPEN]  = (cmd == CMD_ACT) && bank_open;
        hit[V_RW_CLOSED] = (cmd == CMD_RD || cmd == CMD_WR) && !bank_open;
        hit[V_REF_OPEN]  = (cmd == CMD_REF || cmd == CMD_SREF) && any_open;
        hit[V_LMR_OPEN]  = (cmd == CMD_LMR) && any_open;
        hit[V_MRD]       = is_exec(cmd) && (mrd_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mrd_cnt <= '0;
            viol_o  <= '0;
        end else begin
            if (cmd == CMD_LMR)
                mrd_cnt <= CNT_W'(TMRD - 1);
            else if (mrd_cnt != '0)
                mrd_cnt <= mrd_cnt - 1'b1;
            viol_o <= (clr ? '0 : viol_o) | hit;
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdcm_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 12,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 10,
    parameter int NBYTE  = 9,
    parameter int TMRD   = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               clr_viol,
    input  logic                               cs_n,
    input  logic                               ras_n,
    input  logic                               cas_n,
    input  logic                               we_n,
    input  logic                               cke,
    input  logic [BA_W-1:0]                    ba,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [NBYTE-1:0]                   dqm,
    output logic [3:0]                         cmd_o,
    output logic [BA_W-1:0]                    bank_o,
    output logic [ADDR_W-1:0]                  addr_o,
    output logic                               ap_o,
    output logic                               pre_all_o,
    output logic [NBYTE-1:0]                   wr_mask_o,
    output logic [(1<<BA_W)-1:0]               open_o,
    output logic [(1<<BA_W)*ADDR_W-1:0]        open_rows_o,
    output logic [VIOL_W-1:0]                  viol_o
);

    localparam int NBANK = 1 << BA_W;

    sd_dec_t            dec;
    logic [ADDR_W-1:0]  field;
    logic [NBANK-1:0]   open_st;

    sdcm_decoder #(.ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .addr(addr), .dec_o(dec), .field_o(field)
    );

    sdcm_bank_tracker #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_banks (
        .clk(clk), .rst(rst), .dec(dec), .ba(ba), .addr(addr),
        .open_o(open_st), .rows_o(open_rows_o)
    );

    sdcm_rule_checker #(.BA_W(BA_W), .TMRD(TMRD)) u_rules (
        .clk(clk), .rst(rst), .clr(clr_viol), .cmd(dec.cmd), .ba(ba),
        .open_i(open_st), .viol_o(viol_o)
    );

    assign open_o = open_st;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o     <= CMD_INH;
            bank_o    <= '0;
            addr_o    <= '0;
            ap_o      <= 1'b0;
            pre_all_o <= 1'b0;
            wr_mask_o <= '0;
        end else begin
            cmd_o     <= dec.cmd;
            bank_o    <= ba;
            addr_o    <= field;
            ap_o      <= dec.ap;
            pre_all_o <= dec.pre_all;
            if (dec.cmd == CMD_WR)
                wr_mask_o <= dqm;
        end
    end

endmodule

// File: rtl/sdcm_checker.sv
module sdcm_checker
    import sdcm_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    parameter int TMRD   = 2,
    localparam int NBANK = 1 << BA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_viol,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        cmd_o,
    input logic [NBANK-1:0]  open_o,
    input logic [VIOL_W-1:0] viol_o
);

    logic act_pins, pre_pins, exec_pins;
    assign act_pins  = !cs_n && ({ras_n, cas_n, we_n} == 3'b011);
    assign pre_pins  = !cs_n && ({ras_n, cas_n, we_n} == 3'b010);
    assign exec_pins = !cs_n && !(ras_n && cas_n && we_n);

    // R2
    inhibit_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_o == 4'd0));

    // R2
    inhibit_state_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !clr_viol) |=> ($stable(open_o) && $stable(viol_o)));

    // R13
    sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_viol |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

    // R8
    act_on_open_chk: assert property (@(posedge clk) disable iff (rst)
        (act_pins && open_o[ba]) |=> viol_o[V_ACT_OPEN]);

    // R5
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        act_pins |=> open_o[$past(ba)]);

    // R6
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_pins && addr[AP_BIT]) |=> (open_o == '0));

    if (TMRD >= 2) begin : g_mrd
        // R12
        mrd_window_chk: assert property (@(posedge clk) disable iff (rst)
            ((cmd_o == 4'd9) && exec_pins) |=> viol_o[V_MRD]);
    end

endmodule

bind sdram_cmd_monitor sdcm_checker #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .TMRD(TMRD)
) u_sdcm_checker (
    .clk(clk), .rst(rst), .clr_viol(clr_viol), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .open_o(open_o), .viol_o(viol_o)
);

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BA_W  = 2;
    localparam int ADDR_W = 12;
    localparam int NBYTE = 9;
    localparam int TMRD  = 3;

    logic clk = 1'b0;
    logic rst, clr_viol, cs_n, ras_n, cas_n, we_n, cke;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic [NBYTE-1:0]  dqm;
    logic [3:0]        cmd_o;
    logic [BA_W-1:0]   bank_o;
    logic [ADDR_W-1:0] addr_o;
    logic              ap_o, pre_all_o;
    logic [NBYTE-1:0]  wr_mask_o;
    logic [3:0]        open_o;
    logic [4*ADDR_W-1:0] open_rows_o;
    logic [4:0]        viol_o;

    int checks = 0;
    int errs   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_monitor #(.BA_W(BA_W), .ADDR_W(ADDR_W), .NBYTE(NBYTE), .TMRD(TMRD))
    u_sdram_cmd_monitor (
        .clk(clk), .rst(rst), .clr_viol(clr_viol), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
        .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o), .ap_o(ap_o),
        .pre_all_o(pre_all_o), .wr_mask_o(wr_mask_o), .open_o(open_o),
        .open_rows_o(open_rows_o), .viol_o(viol_o)
    );

    typedef struct packed {
        logic        cs, ras, cas, we, ck;
        logic [1:0]  b;
        logic [11:0] a;
        logic [3:0]  cmd;
        logic [11:0] fld;
        logic        ap, pall;
        logic [3:0]  open;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,12'h000, 4'd1,12'h000,1'b0,1'b0,4'b0000},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,2'd0,12'h000, 4'd0,12'h000,1'b0,1'b0,4'b0000},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,12'h033, 4'd9,12'h033,1'b0,1'b0,4'b0000},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,12'h000, 4'd1,12'h000,1'b0,1'b0,4'b0000},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,12'h000, 4'd1,12'h000,1'b0,1'b0,4'b0000},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,2'd1,12'hABC, 4'd2,12'hABC,1'b0,1'b0,4'b0010},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,2'd1,12'h1FF, 4'd3,12'h1FF,1'b0,1'b0,4'b0010},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,2'd1,12'h412, 4'd4,12'h012,1'b1,1'b0,4'b0000},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,2'd2,12'h123, 4'd2,12'h123,1'b0,1'b0,4'b0100},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,2'd3,12'h7FF, 4'd2,12'h7FF,1'b0,1'b0,4'b1100},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,2'd0,12'h000, 4'd5,12'h000,1'b0,1'b0,4'b1100},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,2'd2,12'h000, 4'd6,12'h000,1'b0,1'b0,4'b1000},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,2'd0,12'h400, 4'd6,12'h000,1'b0,1'b1,4'b0000},
        '{1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,12'h000, 4'd7,12'h000,1'b0,1'b0,4'b0000},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,12'h000, 4'd8,12'h000,1'b0,1'b0,4'b0000}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic k, input logic [1:0] b, input logic [11:0] a);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();    drive(1'b0,1'b1,1'b1,1'b1,1'b1,2'd0,12'h000); endtask
    task automatic act(input logic [1:0] b, input logic [11:0] r);
        drive(1'b0,1'b0,1'b1,1'b1,1'b1,b,r); endtask
    task automatic lmr(input logic [11:0] op); drive(1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,op); endtask
    task automatic pre_all(); drive(1'b0,1'b0,1'b1,1'b0,1'b1,2'd0,12'h400); endtask
    task automatic inh();    drive(1'b1,1'b0,1'b0,1'b0,1'b1,2'd0,12'h000); endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; clr_viol = 1'b0; dqm = '0;
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1;
        ba = '0; addr = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R3 reset state
        chk(cmd_o == 4'd0, "R3", "reset cmd", cmd_o, 0);
        chk(open_o == 4'b0 && viol_o == 5'b0, "R3", "reset banks/flags",
            {open_o, viol_o}, 0);
        chk(wr_mask_o == '0, "R3", "reset mask", wr_mask_o, 0);

        // R1 R4 R5 R6 R7 R10 table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cs, VEC[i].ras, VEC[i].cas, VEC[i].we, VEC[i].ck, VEC[i].b, VEC[i].a);
            chk(cmd_o == VEC[i].cmd, "R1", $sformatf("vec %0d cmd", i), cmd_o, VEC[i].cmd);
            chk(addr_o == VEC[i].fld, "R3", $sformatf("vec %0d field", i), addr_o, VEC[i].fld);
            chk(ap_o == VEC[i].ap, "R4", $sformatf("vec %0d ap", i), ap_o, VEC[i].ap);
            chk(pre_all_o == VEC[i].pall, "R6", $sformatf("vec %0d pre_all", i), pre_all_o, VEC[i].pall);
            chk(open_o == VEC[i].open, "R5", $sformatf("vec %0d open", i), open_o, VEC[i].open);
            chk(viol_o == 5'b0, "R10", $sformatf("vec %0d flags", i), viol_o, 0);
        end

        // R5 stored row
        act(2'd0, 12'h345);
        chk(open_o == 4'b0001 && open_rows_o[11:0] == 12'h345, "R5", "bank0 row",
            {open_o, open_rows_o[11:0]}, {4'b0001, 12'h345});
        // R8 activate on open bank
        act(2'd0, 12'h111);
        chk(viol_o == 5'b00001, "R8", "act on open", viol_o, 5'b00001);
        // R13 sticky
        dqm = 9'h1FF;
        nop();
        chk(viol_o == 5'b00001, "R13", "sticky hold", viol_o, 5'b00001);
        clr_viol = 1'b1; nop(); clr_viol = 1'b0;
        chk(viol_o == 5'b0, "R13", "clear", viol_o, 0);
        // R9 read closed bank
        drive(1'b0,1'b1,1'b0,1'b1,1'b1,2'd1,12'h005);
        chk(viol_o == 5'b00010, "R9", "read closed", viol_o, 5'b00010);
        clr_viol = 1'b1; nop(); clr_viol = 1'b0;
        // R10 refresh while open
        drive(1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,12'h000);
        chk(viol_o == 5'b00100 && cmd_o == 4'd7, "R10", "refresh open",
            {cmd_o, viol_o}, {4'd7, 5'b00100});
        clr_viol = 1'b1; nop(); clr_viol = 1'b0;
        // R11 mode load while open
        lmr(12'h020);
        chk(viol_o == 5'b01000, "R11", "mode load open", viol_o, 5'b01000);
        clr_viol = 1'b1; nop(); clr_viol = 1'b0;
        nop();
        pre_all();
        chk(viol_o == 5'b0 && open_o == 4'b0, "R12", "command at window edge",
            {open_o, viol_o}, 0);
        // R2 inhibit with mode-load pattern
        inh();
        chk(cmd_o == 4'd0 && viol_o == 5'b0 && open_o == 4'b0, "R2", "inhibit ignored",
            {cmd_o, open_o, viol_o}, 0);
        // R12 inside window
        lmr(12'h020);
        nop();
        act(2'd2, 12'h010);
        chk(viol_o == 5'b10000, "R12", "inside window", viol_o, 5'b10000);
        clr_viol = 1'b1; nop(); clr_viol = 1'b0;
        pre_all();
        // R2 R12 inhibit does not count in window
        lmr(12'h020);
        inh();
        inh();
        act(2'd1, 12'h0F0);
        chk(viol_o == 5'b0 && open_o == 4'b0010, "R2", "inhibit in window",
            {open_o, viol_o}, {4'b0010, 5'b0});
        // R14 write mask
        dqm = 9'h0A5;
        drive(1'b0,1'b1,1'b0,1'b0,1'b1,2'd1,12'h0AA);
        chk(wr_mask_o == 9'h0A5 && ap_o == 1'b0 && open_o == 4'b0010, "R14", "write mask",
            {wr_mask_o, ap_o, open_o}, {9'h0A5, 1'b0, 4'b0010});
        dqm = 9'h1FF;
        nop();
        chk(wr_mask_o == 9'h0A5, "R14", "mask hold", wr_mask_o, 9'h0A5);
        // R7 read with auto precharge
        drive(1'b0,1'b1,1'b0,1'b1,1'b1,2'd1,12'h403);
        chk(open_o == 4'b0 && ap_o == 1'b1, "R7", "auto precharge close",
            {open_o, ap_o}, {4'b0, 1'b1});

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule